// File: doc/BRIEF.md
# Serial Converter Host-Interface Front End

This block is the digital side of a 10-bit serially controlled analog-to-digital converter. A host talks to it over four wires: an active-low select, a serial clock, a serial channel-address line and a data line with an output enable that stands in for a three-state driver. During one transfer the host shifts in a 4-bit channel number, most significant bit first, and at the same time shifts out the result of the previous conversion. The block counts serial-clock edges, marks the sampling window and then hands the held sample to a conversion engine through a run/done handshake. The analog path is outside the block. The engine is seen only as a level request and a one-cycle completion pulse that carries its code.

All host pins are asynchronous to the block's system clock. Each one passes through a two-stage synchronizer, and edges are detected in the system-clock domain. A change on the select line is taken only after it has held for a set number of system-clock cycles, so short glitches do nothing. Three channel numbers select built-in test levels, and for these the block writes fixed codes instead of the engine's output.

The host may pulse select around every transfer, or it may hold select low the whole time. In the held case the block reloads the output shifter with the new result at the point in the transfer the host expects. Taking select low while a conversion is running aborts that conversion and keeps the stored result.

Top module: `sadc_front`

## Requirements
- R1: The channel number is taken from the address line on the first four serial-clock rising edges after selection, most significant bit first. The address line has no effect on later rising edges of the same transfer.
- R2: When selection is accepted, `dout_oe` goes high and `dout` shows bit 9 of the stored result. Each serial-clock falling edge moves to the next lower bit, so bit 0 is shown after the ninth falling edge.
- R3: From the tenth falling edge until the transfer ends (at most 16 clocks), `dout` is 0.
- R4: `sample_on` is high from the fourth falling edge to the tenth falling edge. On the tenth falling edge `eoc` goes low, `conv_run` goes high and `conv_chan` holds the channel number shifted in.
- R5: `eoc` stays low and `conv_run` stays high until `conv_done` arrives. The result is then stored and `eoc` returns high.
- R6: While deselected, `dout_oe` is low and serial-clock and address activity changes nothing. A new selection resets the edge counters.
- R7: Channel 11 stores 0x200, channel 12 stores 0x000 and channel 13 stores 0x3FF, whatever the engine code. Every other channel stores `conv_code`.
- R8: A selection accepted while a conversion runs drops `conv_run`, returns `eoc` high and leaves the stored result unchanged.
- R9: A select change is accepted only after the synchronized level has differed from the accepted state for 2 consecutive system clocks. A one-cycle pulse is ignored.
- R10: With select held low, when a conversion completes and no eleventh rising edge has occurred, or 16 falling edges have already occurred, the counters reset at once and `dout` shows bit 9 of the new result. If the eleventh rising edge came first, this reload happens on the sixteenth falling edge.
- R11: Serial-clock edges after the sixteenth of each kind are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Host select, active low, asynchronous |
| io_clk | input | 1 | Host serial clock, asynchronous |
| addr_in | input | 1 | Serial channel address, MSB first |
| conv_done | input | 1 | Engine completion pulse |
| conv_code | input | 10 | Engine result code, valid with `conv_done` |
| dout | output | 1 | Serial result bit |
| dout_oe | output | 1 | Output enable for the result line (high-impedance when low) |
| eoc | output | 1 | End of conversion, low while converting |
| conv_run | output | 1 | Conversion request, held until done or abort |
| conv_chan | output | 4 | Channel held for the running conversion |
| sample_on | output | 1 | Sampling window marker |

## Verification
All fourteen channel numbers are swept with select pulsed around each transfer and with transfer lengths cycling from 10 to 16 clocks. Each transfer reads back the code expected from the previous channel, which confirms address capture, test-code substitution and zero fill together. Bits driven after the fourth clock alternate, which shows whether late address bits leak into the captured channel. Held-select runs use three engine latencies: completion before the eleventh edge, completion after all sixteen edges, and completion in between. These separate the immediate-reload and deferred-reload paths. Aborts, one-cycle select glitches during a transfer and clock activity while deselected check that each leaves the result and counters as the requirements say.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    localparam int CODE_W = 10;
    localparam int ADDR_W = 4;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [ADDR_W-1:0] chan_t;

    typedef enum logic [1:0] {
        SRC_ENGINE,
        SRC_MID,
        SRC_ZERO,
        SRC_FULL
    } src_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    localparam chan_t CH_MID  = chan_t'(11);
    localparam chan_t CH_ZERO = chan_t'(12);
    localparam chan_t CH_FULL = chan_t'(13);

    function automatic src_e chan_source(chan_t c);
        case (c)
            CH_MID:  return SRC_MID;
            CH_ZERO: return SRC_ZERO;
            CH_FULL: return SRC_FULL;
            default: return SRC_ENGINE;
        endcase
    endfunction

    function automatic code_t pick_code(chan_t c, code_t eng);
        case (chan_source(c))
            SRC_MID:  return {1'b1, {(CODE_W-1){1'b0}}};
            SRC_ZERO: return '0;
            SRC_FULL: return '1;
            default:  return eng;
        endcase
    endfunction

endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
    parameter int WIDTH = 1,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) stg <= RST_VAL;
                else     stg <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stg <= {STAGES{RST_VAL}};
                else     stg <= {stg[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/sadc_cs_qual.sv
module sadc_cs_qual #(
    parameter int STABLE = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_n_s,
    output logic sel_ok,
    output logic sel_start
);
    localparam int CW = $clog2(STABLE + 1);

    logic [CW-1:0] run_len;
    logic          want;

    assign want = ~sel_n_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_ok    <= 1'b0;
            sel_start <= 1'b0;
            run_len   <= '0;
        end else begin
            sel_start <= 1'b0;
            if (want != sel_ok) begin
                if (run_len == CW'(STABLE - 1)) begin
                    sel_ok    <= want;
                    sel_start <= want;
                    run_len   <= '0;
                end else begin
                    run_len <= run_len + 1'b1;
                end
            end else begin
                run_len <= '0;
            end
        end
    end
endmodule

// File: rtl/sadc_edge.sv
module sadc_edge
    import sadc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  level,
    input  logic  enable,
    output edge_t ev
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= level;
    end

    assign ev.rise = enable & level & ~prev;
    assign ev.fall = enable & ~level & prev;
endmodule

// File: rtl/sadc_front.sv
module sadc_front
    import sadc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SEL_STABLE  = 2,
    parameter int MAX_EDGES   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              io_clk,
    input  logic              addr_in,
    input  logic              conv_done,
    input  logic [CODE_W-1:0] conv_code,
    output logic              dout,
    output logic              dout_oe,
    output logic              eoc,
    output logic              conv_run,
    output logic [ADDR_W-1:0] conv_chan,
    output logic              sample_on
);
    localparam int CNT_W = $clog2(MAX_EDGES + 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] SAMP_PRE  = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] HOLD_PRE  = CNT_W'(CODE_W - 1);
    localparam logic [CNT_W-1:0] HOLD_CNT  = CNT_W'(CODE_W);
    localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(MAX_EDGES);
    localparam logic [CNT_W-1:0] LAST_PRE  = CNT_W'(MAX_EDGES - 1);

    logic [2:0] pins_s;
    logic       sel_ok, sel_start;
    edge_t      ev;

    logic [CNT_W-1:0] rise_cnt, fall_cnt;
    chan_t addr_sh, chan_q;
    code_t result, shreg;
    logic  oe_q, eoc_q, run_q, samp_q, pend_q;
    logic  done_ok, reload_now, reload_late;

    sadc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst(rst),
        .d({sel_n, io_clk, addr_in}),
        .q(pins_s)
    );

    sadc_cs_qual #(.STABLE(SEL_STABLE)) u_qual (
        .clk(clk), .rst(rst),
        .sel_n_s(pins_s[2]),
        .sel_ok(sel_ok),
        .sel_start(sel_start)
    );

    sadc_edge u_edge (
        .clk(clk), .rst(rst),
        .level(pins_s[1]),
        .enable(sel_ok),
        .ev(ev)
    );

    assign done_ok     = run_q & conv_done & ~sel_start;
    assign reload_now  = sel_ok & done_ok & ((rise_cnt <= HOLD_CNT) || (fall_cnt >= CNT_MAX));
    assign reload_late = sel_ok & pend_q & ev.fall & (fall_cnt == LAST_PRE);

    always_ff @(posedge clk) begin
        if (rst) begin
            rise_cnt <= '0;
            fall_cnt <= '0;
            addr_sh  <= '0;
            chan_q   <= '0;
            result   <= '0;
            shreg    <= '0;
            oe_q     <= 1'b0;
            eoc_q    <= 1'b1;
            run_q    <= 1'b0;
            samp_q   <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            oe_q <= sel_ok;
            if (done_ok) begin
                result <= pick_code(chan_q, conv_code);
                run_q  <= 1'b0;
                eoc_q  <= 1'b1;
                pend_q <= sel_ok & ~reload_now;
            end
            if (sel_start) begin
                rise_cnt <= '0;
                fall_cnt <= '0;
                samp_q   <= 1'b0;
                pend_q   <= 1'b0;
                shreg    <= result;
                run_q    <= 1'b0;
                eoc_q    <= 1'b1;
            end else if (reload_now) begin
                rise_cnt <= '0;
                fall_cnt <= '0;
                shreg    <= pick_code(chan_q, conv_code);
            end else if (reload_late) begin
                rise_cnt <= '0;
                fall_cnt <= '0;
                shreg    <= result;
                pend_q   <= 1'b0;
            end else if (sel_ok) begin
                if (ev.rise && rise_cnt < CNT_MAX) begin
                    rise_cnt <= rise_cnt + 1'b1;
                    if (rise_cnt <= ADDR_LAST)
                        addr_sh <= {addr_sh[ADDR_W-2:0], pins_s[0]};
                end
                if (ev.fall && fall_cnt < CNT_MAX) begin
                    fall_cnt <= fall_cnt + 1'b1;
                    shreg    <= {shreg[CODE_W-2:0], 1'b0};
                    if (fall_cnt == SAMP_PRE)
                        samp_q <= 1'b1;
                    if (fall_cnt == HOLD_PRE) begin
                        samp_q <= 1'b0;
                        run_q  <= 1'b1;
                        eoc_q  <= 1'b0;
                        chan_q <= addr_sh;
                    end
                end
            end
            if (!sel_ok) pend_q <= 1'b0;
        end
    end

    assign dout      = oe_q & shreg[CODE_W-1];
    assign dout_oe   = oe_q;
    assign eoc       = eoc_q;
    assign conv_run  = run_q;
    assign conv_chan = chan_q;
    assign sample_on = samp_q;
endmodule

// File: rtl/sadc_front_chk.sv
module sadc_front_chk
    import sadc_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int MAX_EDGES = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             sel_ok,
    input logic             dout_oe,
    input logic             dout,
    input logic             eoc,
    input logic             conv_run,
    input logic             conv_done,
    input logic             sample_on,
    input logic [CNT_W-1:0] fall_cnt,
    input code_t            result
);
    p_oe_follows_select_r6: assert property (@(posedge clk) disable iff (rst)
        !sel_ok |=> !dout_oe);

    p_zero_fill_r3: assert property (@(posedge clk) disable iff (rst)
        (dout_oe && fall_cnt >= CNT_W'(CODE_W)) |-> !dout);

    p_low_eoc_running_r5: assert property (@(posedge clk) disable iff (rst)
        !eoc |-> conv_run);

    p_done_raises_eoc_r5: assert property (@(posedge clk) disable iff (rst)
        (conv_run && conv_done) |=> eoc);

    p_result_kept_r8: assert property (@(posedge clk) disable iff (rst)
        !(conv_run && conv_done) |=> $stable(result));

    p_window_disjoint_r4: assert property (@(posedge clk) disable iff (rst)
        !(sample_on && conv_run));

    p_count_cap_r11: assert property (@(posedge clk) disable iff (rst)
        fall_cnt <= CNT_W'(MAX_EDGES));
endmodule

bind sadc_front sadc_front_chk #(.CNT_W(CNT_W), .MAX_EDGES(MAX_EDGES)) u_chk (
    .clk(clk),
    .rst(rst),
    .sel_ok(sel_ok),
    .dout_oe(dout_oe),
    .dout(dout),
    .eoc(eoc),
    .conv_run(conv_run),
    .conv_done(conv_done),
    .sample_on(sample_on),
    .fall_cnt(fall_cnt),
    .result(result)
);

// File: tb/sadc_front_bench.sv
`timescale 1ns/1ps
module sadc_front_bench;
    import sadc_pkg::*;

    localparam int H = 8;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    logic  sel_n = 1'b1;
    logic  io_clk = 1'b0;
    logic  addr_in = 1'b0;
    logic  conv_done = 1'b0;
    code_t conv_code;
    logic  dout, dout_oe, eoc, conv_run, sample_on;
    chan_t conv_chan;

    int checks = 0;
    int errors = 0;
    int lat = 40;
    int eng_cnt = 0;
    code_t prev;
    logic [19:0] bits, samp;

    always #2.5 clk = ~clk;

    sadc_front u_sadc_front (
        .clk(clk), .rst(rst), .sel_n(sel_n), .io_clk(io_clk), .addr_in(addr_in),
        .conv_done(conv_done), .conv_code(conv_code), .dout(dout), .dout_oe(dout_oe),
        .eoc(eoc), .conv_run(conv_run), .conv_chan(conv_chan), .sample_on(sample_on)
    );

    function automatic code_t ext_code(chan_t c);
        return code_t'((int'(c) * 71 + 9) % 1024);
    endfunction

    function automatic code_t exp_code(chan_t c);
        case (int'(c))
            11: return code_t'(10'h200);
            12: return code_t'(10'h000);
            13: return code_t'(10'h3FF);
            default: return ext_code(c);
        endcase
    endfunction

    assign conv_code = ext_code(conv_chan);

    always @(posedge clk) begin
        if (!conv_run) begin
            eng_cnt   <= 0;
            conv_done <= 1'b0;
        end else begin
            eng_cnt   <= eng_cnt + 1;
            conv_done <= (eng_cnt == lat);
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic xfer(chan_t ch, int i0, int n);
        for (int i = i0; i < n; i++) begin
            @(negedge clk);
            bits[19-i] = dout;
            samp[19-i] = sample_on;
            addr_in = (i < 4) ? ch[3-i] : i[0];
            io_clk = 1'b1;
            repeat (H) @(negedge clk);
            io_clk = 1'b0;
            repeat (H) @(negedge clk);
        end
        repeat (6) @(negedge clk);
    endtask

    function automatic logic [9:0] fill_mask(int n);
        logic [19:0] m;
        m = (20'h1 << (n - 10)) - 20'h1;
        m = m << (20 - n);
        return m[9:0];
    endfunction

    task automatic select_now();
        sel_n = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic deselect_now();
        sel_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic wait_eoc();
        for (int k = 0; k < 5000 && !eoc; k++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        prev = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check("R5 reset eoc", 32'(eoc), 32'd1);
        check("R6 reset oe", 32'(dout_oe), 32'd0);
        check("R5 reset run", 32'(conv_run), 32'd0);

        // R9: one-cycle select pulse while idle
        sel_n = 1'b0; @(negedge clk); sel_n = 1'b1;
        repeat (12) @(negedge clk);
        check("R9 glitch ignored", 32'(dout_oe), 32'd0);

        // R6: clocking while deselected does nothing
        for (int k = 0; k < 20; k++) begin
            addr_in = k[0]; io_clk = 1'b1; repeat (H) @(negedge clk);
            io_clk = 1'b0; repeat (H) @(negedge clk);
        end
        check("R6 no conversion when idle", 32'(conv_run), 32'd0);
        check("R6 eoc idle", 32'(eoc), 32'd1);

        // Sweep over all channels, transfer lengths 10..16
        for (int c = 0; c < 14; c++) begin
            int n;
            n = 10 + (c % 7);
            bits = '0; samp = '0;
            select_now();
            check("R2 msb at select", 32'(dout), 32'(prev[9]));
            if (c == 0) check("R6 oe when selected", 32'(dout_oe), 32'd1);
            xfer(chan_t'(c), 0, n);
            check("R2 previous result", 32'(bits[19:10]), 32'(prev));
            if (n > 10) check("R3 zero fill", 32'(bits[9:0] & fill_mask(n)), 32'd0);
            if (n == 10) begin
                check("R4 eoc low after tenth", 32'(eoc), 32'd0);
                check("R4 channel held", 32'(conv_chan), 32'(c));
                check("R4 window", 32'(samp), 32'h0FC00);
            end
            deselect_now();
            check("R6 oe off", 32'(dout_oe), 32'd0);
            wait_eoc();
            check("R5 eoc back high", 32'(eoc), 32'd1);
            prev = exp_code(chan_t'(c));
        end

        // R9: glitch in mid-transfer
        bits = '0; samp = '0;
        select_now();
        xfer(chan_t'(3), 0, 4);
        sel_n = 1'b1; @(negedge clk); sel_n = 1'b0;
        xfer(chan_t'(3), 4, 10);
        check("R9 transfer survives glitch", 32'(bits[19:10]), 32'(prev));
        check("R9 conversion started", 32'(eoc), 32'd0);
        deselect_now(); wait_eoc();
        prev = exp_code(chan_t'(3));

        // R8: abort
        lat = 300;
        select_now();
        xfer(chan_t'(5), 0, 10);
        deselect_now();
        check("R8 converting", 32'(eoc), 32'd0);
        select_now();
        check("R8 eoc after abort", 32'(eoc), 32'd1);
        check("R8 run dropped", 32'(conv_run), 32'd0);
        bits = '0;
        xfer(chan_t'(6), 0, 10);
        check("R8 result kept", 32'(bits[19:10]), 32'(prev));
        deselect_now(); wait_eoc();
        prev = exp_code(chan_t'(6));

        // R10: held select, conversion ends before eleventh edge
        lat = 20;
        select_now();
        bits = '0;
        xfer(chan_t'(10), 0, 10);
        check("R2 held first read", 32'(bits[19:10]), 32'(prev));
        wait_eoc();
        check("R10 msb after eoc", 32'(dout), 32'(exp_code(chan_t'(10)) >> 9));
        bits = '0;
        xfer(chan_t'(7), 0, 10);
        check("R10 reload value", 32'(bits[19:10]), 32'(exp_code(chan_t'(10))));
        wait_eoc();
        prev = exp_code(chan_t'(7));

        // R11: held select, 18 clocks, conversion ends after all edges
        lat = 300;
        bits = '0;
        xfer(chan_t'(8), 0, 18);
        check("R11 read before extra", 32'(bits[19:10]), 32'(prev));
        check("R3 zero fill long", 32'(bits[9:0] & fill_mask(18)), 32'd0);
        wait_eoc();
        check("R11 msb after late done", 32'(dout), 32'(exp_code(chan_t'(8)) >> 9));
        bits = '0;
        xfer(chan_t'(9), 0, 16);
        check("R11 reload after extra clocks", 32'(bits[19:10]), 32'(exp_code(chan_t'(8))));
        wait_eoc();
        prev = exp_code(chan_t'(9));

        // R10: held select, conversion ends between eleventh and sixteenth edge
        lat = 60;
        bits = '0;
        xfer(chan_t'(13), 0, 16);
        check("R10 slow read", 32'(bits[19:10]), 32'(prev));
        check("R10 eoc high before end", 32'(eoc), 32'd1);
        check("R10 msb after sixteenth", 32'(dout), 32'd1);
        bits = '0;
        xfer(chan_t'(11), 0, 16);
        check("R7 full code", 32'(bits[19:10]), 32'h3FF);
        check("R3 zero fill slow", 32'(bits[9:0] & fill_mask(16)), 32'd0);
        deselect_now(); wait_eoc();
        select_now();
        bits = '0;
        xfer(chan_t'(0), 0, 10);
        check("R7 mid code", 32'(bits[19:10]), 32'h200);
        check("R1 channel zero held", 32'(conv_chan), 32'd0);
        deselect_now(); wait_eoc();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule